// File: doc/BRIEF.md
# Two-Level Trap Arbiter with Context Save

This block decides which of a processor's pending trap requests is taken in a given cycle. It records the return context for that trap and restores the context when a handler returns. There are thirteen request lines, each at a fixed position. The block gates each line with the enable bits of the current state word and then picks the most urgent line that is allowed through. The chosen trap falls into one of three classes: reset, critical or noncritical. Each of the two lower classes has its own pair of save registers: one register holds the return address and the other holds the saved state word.

In the cycle after a trap is chosen, the block does four things. It raises a one-cycle entry strobe, presents a 4-bit code that outside logic can use for vector lookup, writes the save pair for the trap's class, and outputs a new state word for the core to load. The return address depends on the trap. If a multicycle instruction is in flight, that instruction is aborted and its own address is saved. Otherwise a synchronous fault saves the address of the faulting instruction, and all other traps save the next sequential address. When the core signals a return, the block outputs the saved address and state of the matching class.

Top module: `trap_ctl`

## Requirements
- R1: The line index is also the priority, with 0 the most urgent. The codes are 0 system reset, 1 machine check, 2 debug, 3 critical pin, 4 watchdog first time-out, 5 program, 6 data storage, 7 TLB miss, 8 system call, 9 alignment, 10 external, 11 fixed interval timer and 12 programmable interval timer. `entry_code` reports the lowest index among the accepted lines.
- R2: `entry_cls` reports the class of the taken trap: 0 for reset (code 0), 1 for critical (codes 1 to 4) and 2 for noncritical (codes 5 to 12).
- R3: For a noncritical trap taken with `mc_busy` low, SRR0 receives a return address. Codes 5, 6, 7 and 9 save `cur_pc`. Code 8 and the asynchronous codes 10 to 12 save `seq_pc`.
- R4: Whenever a trap of either class is taken with `mc_busy` high, the saved return address is `cur_pc`.
- R5: A noncritical trap writes `msr_in` into SRR1. The new state word is `msr_in` with bit 15 (noncritical enable) cleared. SRR2 and SRR3 keep their values.
- R6: A critical trap writes the return address into SRR2 and `msr_in` into SRR3. With `mc_busy` low that address is `seq_pc`. The new state word is `msr_in` with bits 15 and 17 (critical enable) both cleared. SRR0 and SRR1 keep their values.
- R7: Code 0 produces the state word `RESET_MSR` (default 0) and leaves all four save registers unchanged.
- R8: Codes 3 and 4 are accepted only while `msr_in` bit 17 is set. Codes 10 to 12 are accepted only while bit 15 is set. All other lines are always accepted. When a line is masked, the next lower accepted line is taken, and with none accepted nothing is taken.
- R9: With no trap taken, a pulse on `rfi_stb` drives `pc_out` from SRR0 and `msr_out` from SRR1, with `pc_wr` and `msr_wr` high for one cycle. A pulse on `rfci_stb` does the same from SRR2 and SRR3.
- R10: `entry_stb` is high only in the cycle after an accepted request. A taken trap overrides a return strobe in the same cycle, so `pc_wr` stays low.
- R11: A synchronous reset on `rst` clears all outputs and all four save registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 13 | Trap request lines, index = priority |
| cur_pc | input | 32 | Address of the current instruction |
| seq_pc | input | 32 | Next sequential address |
| mc_busy | input | 1 | Multicycle instruction in progress |
| msr_in | input | 32 | Current state word |
| rfi_stb | input | 1 | Return from noncritical handler |
| rfci_stb | input | 1 | Return from critical handler |
| entry_stb | output | 1 | One-cycle handler entry pulse |
| entry_code | output | 4 | Code of the taken trap |
| entry_cls | output | 2 | Class of the taken trap |
| msr_wr | output | 1 | New state word valid |
| msr_out | output | 32 | New state word |
| pc_wr | output | 1 | Return address valid |
| pc_out | output | 32 | Return address |
| srr0_q | output | 32 | Noncritical return address |
| srr1_q | output | 32 | Noncritical saved state |
| srr2_q | output | 32 | Critical return address |
| srr3_q | output | 32 | Critical saved state |

## Verification
The arbitration table uses several kinds of request pattern. Some have every line high, to expose an inversion of the priority order. Some have single lines high, to confirm that each code is reported. Some pair masked lines with unmasked lower ones, to show that gating moves the choice down rather than dropping the request. The directed part gives each trap different values for `cur_pc` and `seq_pc`, so every choice of saved address can be told apart. It also checks that the save pair of the other class keeps its value, and that a return strobe loses to a trap taken in the same cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int N_SRC  = 13;
  localparam int CODE_W = $clog2(N_SRC);

  typedef enum logic [1:0] {
    CLS_RESET   = 2'd0,
    CLS_CRIT    = 2'd1,
    CLS_NONCRIT = 2'd2
  } trap_cls_e;

  // bit i set: line i belongs to the group
  localparam logic [N_SRC-1:0] SYNC_MASK = 13'h03E4; // 2,5..9
  localparam logic [N_SRC-1:0] CRIT_MASK = 13'h001E; // 1..4
  localparam logic [N_SRC-1:0] CE_GATE   = 13'h0018; // 3,4
  localparam logic [N_SRC-1:0] EE_GATE   = 13'h1C00; // 10..12

  localparam int RESET_IDX   = 0;
  localparam int SYSCALL_IDX = 8;
endpackage

// File: rtl/trap_sel.sv
module trap_sel
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int EE_BIT = 15,
  parameter int CE_BIT = 17
) (
  input  logic [N_SRC-1:0]  req,
  input  logic [XLEN-1:0]   msr_in,
  output logic              hit,
  output logic [CODE_W-1:0] idx
);
  logic [N_SRC-1:0] ok;

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    if (CE_GATE[g]) begin : g_ce
      assign ok[g] = req[g] & msr_in[CE_BIT];
    end else if (EE_GATE[g]) begin : g_ee
      assign ok[g] = req[g] & msr_in[EE_BIT];
    end else begin : g_open
      assign ok[g] = req[g];
    end
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (ok[i]) begin
        hit = 1'b1;
        idx = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/trap_save.sv
module trap_save #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_nc,
  input  logic            take_cr,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [XLEN-1:0] msr_in,
  output logic [XLEN-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q,
  output logic [XLEN-1:0] srr2_q,
  output logic [XLEN-1:0] srr3_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_q <= '0;
      srr1_q <= '0;
      srr2_q <= '0;
      srr3_q <= '0;
    end else if (take_cr) begin
      srr2_q <= ret_pc;
      srr3_q <= msr_in;
    end else if (take_nc) begin
      srr0_q <= ret_pc;
      srr1_q <= msr_in;
    end
  end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              EE_BIT    = 15,
  parameter int              CE_BIT    = 17,
  parameter logic [XLEN-1:0] RESET_MSR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic              mc_busy,
  input  logic [XLEN-1:0]   msr_in,
  input  logic              rfi_stb,
  input  logic              rfci_stb,
  output logic              entry_stb,
  output logic [CODE_W-1:0] entry_code,
  output logic [1:0]        entry_cls,
  output logic              msr_wr,
  output logic [XLEN-1:0]   msr_out,
  output logic              pc_wr,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   srr0_q,
  output logic [XLEN-1:0]   srr1_q,
  output logic [XLEN-1:0]   srr2_q,
  output logic [XLEN-1:0]   srr3_q
);
  localparam logic [XLEN-1:0] EE_M = XLEN'(1) << EE_BIT;
  localparam logic [XLEN-1:0] CE_M = XLEN'(1) << CE_BIT;

  logic              hit;
  logic [CODE_W-1:0] idx;
  trap_cls_e         cls;
  logic              sync_fault;
  logic              take_nc, take_cr;
  logic [XLEN-1:0]   ret_pc;
  logic [XLEN-1:0]   msr_new;

  trap_sel #(.XLEN(XLEN), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT)) u_sel (
    .req(req), .msr_in(msr_in), .hit(hit), .idx(idx)
  );

  always_comb begin
    if (idx == CODE_W'(RESET_IDX))  cls = CLS_RESET;
    else if (CRIT_MASK[idx])        cls = CLS_CRIT;
    else                            cls = CLS_NONCRIT;
    sync_fault = SYNC_MASK[idx] && (idx != CODE_W'(SYSCALL_IDX));
    take_nc    = hit && (cls == CLS_NONCRIT);
    take_cr    = hit && (cls == CLS_CRIT);
    if (mc_busy)                                   ret_pc = cur_pc;
    else if (cls == CLS_NONCRIT && sync_fault)     ret_pc = cur_pc;
    else                                           ret_pc = seq_pc;
    case (cls)
      CLS_RESET: msr_new = RESET_MSR;
      CLS_CRIT:  msr_new = msr_in & ~(EE_M | CE_M);
      default:   msr_new = msr_in & ~EE_M;
    endcase
  end

  trap_save #(.XLEN(XLEN)) u_save (
    .clk(clk), .rst(rst), .take_nc(take_nc), .take_cr(take_cr),
    .ret_pc(ret_pc), .msr_in(msr_in),
    .srr0_q(srr0_q), .srr1_q(srr1_q), .srr2_q(srr2_q), .srr3_q(srr3_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_stb  <= 1'b0;
      entry_code <= '0;
      entry_cls  <= 2'd0;
      msr_wr     <= 1'b0;
      msr_out    <= '0;
      pc_wr      <= 1'b0;
      pc_out     <= '0;
    end else begin
      entry_stb <= 1'b0;
      msr_wr    <= 1'b0;
      pc_wr     <= 1'b0;
      if (hit) begin
        entry_stb  <= 1'b1;
        entry_code <= idx;
        entry_cls  <= cls;
        msr_wr     <= 1'b1;
        msr_out    <= msr_new;
      end else if (rfci_stb) begin
        pc_wr   <= 1'b1;
        pc_out  <= srr2_q;
        msr_wr  <= 1'b1;
        msr_out <= srr3_q;
      end else if (rfi_stb) begin
        pc_wr   <= 1'b1;
        pc_out  <= srr0_q;
        msr_wr  <= 1'b1;
        msr_out <= srr1_q;
      end
    end
  end
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int EE_BIT = 15,
  parameter int CE_BIT = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  req,
  input logic              entry_stb,
  input logic [CODE_W-1:0] entry_code,
  input logic [1:0]        entry_cls,
  input logic              msr_wr,
  input logic [XLEN-1:0]   msr_out,
  input logic              pc_wr,
  input logic [XLEN-1:0]   srr0_q,
  input logic [XLEN-1:0]   srr1_q,
  input logic [XLEN-1:0]   srr2_q,
  input logic [XLEN-1:0]   srr3_q
);
  a_r10_entry_needs_req: assert property (@(posedge clk) disable iff (rst)
    entry_stb |-> $past(|req));

  a_r10_entry_beats_return: assert property (@(posedge clk) disable iff (rst)
    entry_stb |-> !pc_wr);

  a_r2_crit_codes: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_code >= 4'd1 && entry_code <= 4'd4) |-> entry_cls == 2'd1);

  a_r5_nc_keeps_crit_pair: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_cls == 2'd2) |-> ($stable(srr2_q) && $stable(srr3_q)));

  a_r5_nc_clears_ee: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_cls == 2'd2) |-> (msr_wr && !msr_out[EE_BIT]));

  a_r6_crit_keeps_nc_pair: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_cls == 2'd1) |-> ($stable(srr0_q) && $stable(srr1_q)));

  a_r6_crit_clears_enables: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_cls == 2'd1) |-> (!msr_out[EE_BIT] && !msr_out[CE_BIT]));

  a_r7_reset_keeps_all: assert property (@(posedge clk) disable iff (rst)
    (entry_stb && entry_cls == 2'd0) |->
      ($stable(srr0_q) && $stable(srr1_q) && $stable(srr2_q) && $stable(srr3_q)));
endmodule

bind trap_ctl trap_ctl_chk #(.XLEN(XLEN), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT)) u_chk (
  .clk(clk), .rst(rst), .req(req), .entry_stb(entry_stb),
  .entry_code(entry_code), .entry_cls(entry_cls), .msr_wr(msr_wr),
  .msr_out(msr_out), .pc_wr(pc_wr), .srr0_q(srr0_q), .srr1_q(srr1_q),
  .srr2_q(srr2_q), .srr3_q(srr3_q)
);

// File: tb/sim_trap_ctl.sv
module sim_trap_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [31:0] BASE = 32'h0000_00A0;
  localparam logic [31:0] EE = 32'h0000_8000;
  localparam logic [31:0] CE = 32'h0002_0000;
  localparam logic [31:0] M1 = BASE | EE;
  localparam logic [31:0] M2 = BASE | EE | CE;

  // {req, ee, ce, exp_hit, exp_code}
  localparam logic [19:0] VECS [NV] = '{
    {13'h1FFF, 1'b1, 1'b1, 1'b1, 4'd0},
    {13'h1FFE, 1'b1, 1'b1, 1'b1, 4'd1},
    {13'h1FFC, 1'b1, 1'b1, 1'b1, 4'd2},
    {13'h1FF8, 1'b1, 1'b1, 1'b1, 4'd3},
    {13'h1FF8, 1'b1, 1'b0, 1'b1, 4'd5},
    {13'h1C10, 1'b1, 1'b1, 1'b1, 4'd4},
    {13'h1C10, 1'b1, 1'b0, 1'b1, 4'd10},
    {13'h1C00, 1'b0, 1'b1, 1'b0, 4'd0},
    {13'h1800, 1'b1, 1'b0, 1'b1, 4'd11},
    {13'h1000, 1'b1, 1'b0, 1'b1, 4'd12},
    {13'h0200, 1'b0, 1'b0, 1'b1, 4'd9},
    {13'h0180, 1'b0, 1'b0, 1'b1, 4'd7},
    {13'h0002, 1'b0, 1'b0, 1'b1, 4'd1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [12:0] req = '0;
  logic [31:0] cur_pc = '0, seq_pc = '0, msr_in = '0;
  logic mc_busy = 1'b0, rfi_stb = 1'b0, rfci_stb = 1'b0;
  logic entry_stb, msr_wr, pc_wr;
  logic [3:0] entry_code;
  logic [1:0] entry_cls;
  logic [31:0] msr_out, pc_out, srr0_q, srr1_q, srr2_q, srr3_q;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ctl u0 (
    .clk(clk), .rst(rst), .req(req), .cur_pc(cur_pc), .seq_pc(seq_pc),
    .mc_busy(mc_busy), .msr_in(msr_in), .rfi_stb(rfi_stb), .rfci_stb(rfci_stb),
    .entry_stb(entry_stb), .entry_code(entry_code), .entry_cls(entry_cls),
    .msr_wr(msr_wr), .msr_out(msr_out), .pc_wr(pc_wr), .pc_out(pc_out),
    .srr0_q(srr0_q), .srr1_q(srr1_q), .srr2_q(srr2_q), .srr3_q(srr3_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_of(input logic [3:0] code);
    if (code == 4'd0) return 2'd0;
    if (code <= 4'd4) return 2'd1;
    return 2'd2;
  endfunction

  // drive for one edge, sample after it, then idle one edge and confirm strobes drop
  task automatic fire(input logic [12:0] r, input logic [31:0] cp, input logic [31:0] sp,
                      input logic mc, input logic [31:0] m, input logic ri, input logic rc);
    req = r; cur_pc = cp; seq_pc = sp; mc_busy = mc; msr_in = m; rfi_stb = ri; rfci_stb = rc;
    @(negedge clk);
    req = '0; mc_busy = 1'b0; rfi_stb = 1'b0; rfci_stb = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R10 strobe drops", {30'd0, entry_stb, pc_wr}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 R2 R8: arbitration table
    for (int v = 0; v < NV; v++) begin
      fire(VECS[v][19:7], 32'h10, 32'h14, 1'b0,
           BASE | (VECS[v][6] ? EE : 32'd0) | (VECS[v][5] ? CE : 32'd0), 1'b0, 1'b0);
      chk("R8 hit", {31'd0, entry_stb}, {31'd0, VECS[v][4]});
      if (VECS[v][4]) begin
        chk("R1 code", {28'd0, entry_code}, {28'd0, VECS[v][3:0]});
        chk("R2 class", {30'd0, entry_cls}, {30'd0, cls_of(VECS[v][3:0])});
      end
      idle_check();
    end

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    // R11 reset state
    chk("R11 outputs", {29'd0, entry_stb, msr_wr, pc_wr}, 32'd0);
    chk("R11 msr_out", msr_out, 32'd0);
    chk("R11 srr", srr0_q | srr1_q | srr2_q | srr3_q, 32'd0);

    // R3 R5 program fault saves current pc
    fire(13'h0020, 32'h100, 32'h104, 1'b0, M1, 1'b0, 1'b0);
    chk("R3 fault pc", srr0_q, 32'h100);
    chk("R5 srr1", srr1_q, M1);
    chk("R5 new msr", msr_out, BASE);
    chk("R5 crit pair kept", srr2_q | srr3_q, 32'd0);
    idle_check();
    // R3 system call saves next pc
    fire(13'h0100, 32'h200, 32'h204, 1'b0, M1, 1'b0, 1'b0);
    chk("R3 syscall pc", srr0_q, 32'h204);
    idle_check();
    // R3 external saves next pc
    fire(13'h0400, 32'h300, 32'h308, 1'b0, M1, 1'b0, 1'b0);
    chk("R3 async pc", srr0_q, 32'h308);
    idle_check();
    // R4 multicycle noncritical
    fire(13'h0400, 32'h400, 32'h404, 1'b1, M1, 1'b0, 1'b0);
    chk("R4 nc multicycle", srr0_q, 32'h400);
    idle_check();
    // R6 critical pin
    fire(13'h0008, 32'h500, 32'h504, 1'b0, M2, 1'b0, 1'b0);
    chk("R6 srr2", srr2_q, 32'h504);
    chk("R6 srr3", srr3_q, M2);
    chk("R6 new msr", msr_out, BASE);
    chk("R6 srr0 kept", srr0_q, 32'h400);
    chk("R6 srr1 kept", srr1_q, M1);
    idle_check();
    // R4 multicycle critical
    fire(13'h0008, 32'h600, 32'h604, 1'b1, M2, 1'b0, 1'b0);
    chk("R4 crit multicycle", srr2_q, 32'h600);
    idle_check();
    // R7 system reset source
    fire(13'h0001, 32'h700, 32'h704, 1'b0, M2, 1'b0, 1'b0);
    chk("R7 class", {30'd0, entry_cls}, 32'd0);
    chk("R7 msr", msr_out, 32'd0);
    chk("R7 srr0 kept", srr0_q, 32'h400);
    chk("R7 srr2 kept", srr2_q, 32'h600);
    chk("R7 srr3 kept", srr3_q, M2);
    idle_check();
    // R9 returns
    fire(13'h0000, 32'h0, 32'h0, 1'b0, 32'd0, 1'b1, 1'b0);
    chk("R9 rfi pc_wr", {31'd0, pc_wr}, 32'd1);
    chk("R9 rfi pc", pc_out, 32'h400);
    chk("R9 rfi msr", msr_out, M1);
    idle_check();
    fire(13'h0000, 32'h0, 32'h0, 1'b0, 32'd0, 1'b0, 1'b1);
    chk("R9 rfci pc", pc_out, 32'h600);
    chk("R9 rfci msr", msr_out, M2);
    idle_check();
    // R10 trap beats return in same cycle
    fire(13'h0020, 32'h800, 32'h804, 1'b0, M1, 1'b1, 1'b0);
    chk("R10 entry", {31'd0, entry_stb}, 32'd1);
    chk("R10 no pc_wr", {31'd0, pc_wr}, 32'd0);
    chk("R10 srr0", srr0_q, 32'h800);
    idle_check();
    // R8 masked critical pin leaves critical pair alone
    fire(13'h0008, 32'h900, 32'h904, 1'b0, EE, 1'b0, 1'b0);
    chk("R8 masked no entry", {31'd0, entry_stb}, 32'd0);
    chk("R8 srr2 kept", srr2_q, 32'h600);
    idle_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule